// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Interface

This block is the view that one processor has of a shared interrupt distributor. Each cycle it looks at the interrupts that are both enabled and pending for this processor and finds the most urgent one. It compares that candidate with a programmable priority mask and with the priority of the interrupt being serviced now, and it drives one interrupt request line to the processor.

Software reaches the block through a small register window. A read of the acknowledge register takes the best candidate into service and asks the distributor to drop its pending state. A write of an interrupt number to the end-of-interrupt register retires it. Every interrupt in service records which interrupt it preempted, so the in-service interrupts form a chain. Retiring the newest entry returns to its predecessor. Retiring an older entry removes it from the middle of the chain with a short sequential walk, and the block reports busy while the walk runs.

The distributor keeps the pending flags. This block only sends it one-cycle clear and set strobes.

Top module: `cpuif_top`

## Requirements
- R1: After reset the control enable reads 0, the mask reads 0xF0, the running priority reads 0x100, the highest-pending register reads 1023, and `irq_o` is low.
- R2: The highest-pending register (offset 0x18) holds the enabled and pending interrupt with the numerically lowest priority value. On a priority tie the lowest interrupt number wins. It reads 1023 when there is no candidate.
- R3: A candidate is shown in the highest-pending register only if its priority is less than or equal to the mask (offset 0x04). Otherwise that register reads 1023.
- R4: `irq_o` is high exactly when the highest-pending register holds a valid number whose priority is strictly below the running priority. Both values follow input changes one clock later.
- R5: When the control enable (offset 0x00, bit 0) is 0 or `dist_en_i` is low, `irq_o` is low and the highest-pending register reads 1023.
- R6: A read of offset 0x0C returns the highest-pending number when its priority is strictly below the running priority. It then makes that number the running interrupt, sets the running priority (offset 0x14) to its priority, and pulses bit `id` of `pend_clr_o` in the same cycle. In every other case the read returns 1023 and has no effect.
- R7: An accepted acknowledge of an interrupt whose `irq_bcast_i` bit is set also pulses `pend_clr_all_o`. The bit is 0 for all other acknowledges.
- R8: A write to offset 0x10 whose low 10 bits equal the running interrupt makes that interrupt's predecessor the running interrupt. The running priority becomes the predecessor's priority, or 0x100 when there is no predecessor.
- R9: A write to offset 0x10 naming an interrupt deeper in the chain removes it from the chain. `busy_o` is high while the walk runs, every register access during that time is ignored, and later returns skip the removed entry.
- R10: A write to offset 0x10 while nothing is running, or with a number at or above `N_IRQ`, changes no state and gives no strobe.
- R11: An accepted write to offset 0x10 pulses bit `id` of `pend_set_o` when that interrupt is level-sensitive (`irq_edge_i` bit 0), enabled, its level is high, and its `irq_tgt_i` bit is set. Edge-sensitive interrupts give no pulse.
- R12: The control enable and the 8-bit mask read back as written. A read of any offset not listed above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dist_en_i | input | 1 | Global distribution enable |
| irq_en_i | input | N_IRQ | Per-interrupt enable for this CPU |
| irq_pend_i | input | N_IRQ | Per-interrupt pending flag for this CPU |
| irq_prio_i | input | N_IRQ*8 | Priority of interrupt i in bits [8i+7:8i] |
| irq_level_i | input | N_IRQ | Current input level |
| irq_edge_i | input | N_IRQ | 1 = edge-sensitive, 0 = level-sensitive |
| irq_bcast_i | input | N_IRQ | 1 = an acknowledge clears pending on all CPUs |
| irq_tgt_i | input | N_IRQ | This CPU is in the interrupt's target set |
| reg_req_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 5 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the access cycle |
| busy_o | output | 1 | Chain walk in progress; accesses are ignored |
| irq_o | output | 1 | Interrupt request to the CPU |
| pend_clr_o | output | N_IRQ | One-hot pending clear for this CPU |
| pend_clr_all_o | output | 1 | Apply the pending clear to all CPUs |
| pend_set_o | output | N_IRQ | One-hot pending set for this CPU |

## Verification
A corrupt predecessor link stays hidden until a later end-of-interrupt. It then shows up at the ports as a wrong running priority at offset 0x14 or as a chain that returns to an interrupt already retired. For that reason the bench retires nested interrupts out of order and reads the running priority after each return. A wrong highest-pending or running value shows on `irq_o` and in the acknowledge result one cycle after the inputs settle. The bench checks these after random enable, pending and priority patterns that contain many ties.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int          ID_W   = 10;
  localparam int          PRIO_W = 8;
  localparam logic [9:0]  NO_IRQ = 10'd1023;
  localparam logic [8:0]  IDLE_PRIO = 9'h100;

  localparam logic [4:0] OFF_CTRL = 5'h00;
  localparam logic [4:0] OFF_MASK = 5'h04;
  localparam logic [4:0] OFF_ACK  = 5'h0C;
  localparam logic [4:0] OFF_EOI  = 5'h10;
  localparam logic [4:0] OFF_RPRI = 5'h14;
  localparam logic [4:0] OFF_HPP  = 5'h18;

  typedef enum logic {WALK_IDLE, WALK_RUN} walk_st_e;
endpackage

// File: rtl/cpuif_select.sv
module cpuif_select
  import cpuif_pkg::*;
#(
  parameter int N_IRQ = 32
) (
  input  logic [N_IRQ-1:0]        cand_i,
  input  logic [N_IRQ*PRIO_W-1:0] prio_i,
  output logic                    found_o,
  output logic [ID_W-1:0]         id_o,
  output logic [PRIO_W-1:0]       prio_o
);
  // ascending scan with strict compare: ties go to the lowest number
  always_comb begin
    found_o = 1'b0;
    id_o    = NO_IRQ;
    prio_o  = '1;
    for (int i = 0; i < N_IRQ; i++) begin
      if (cand_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
        found_o = 1'b1;
        id_o    = ID_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/cpuif_chain.sv
module cpuif_chain
  import cpuif_pkg::*;
#(
  parameter int N_IRQ = 32,
  localparam int IW   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_IRQ*PRIO_W-1:0] prio_i,
  input  logic                    ack_i,
  input  logic [ID_W-1:0]         ack_id_i,
  input  logic                    eoi_i,
  input  logic [ID_W-1:0]         eoi_id_i,
  output logic [ID_W-1:0]         run_id_o,
  output logic [PRIO_W:0]         run_prio_o,
  output logic                    busy_o
);
  logic [ID_W-1:0]   link_q [N_IRQ];
  logic [ID_W-1:0]   run_id_q, cur_q, tgt_q;
  logic [PRIO_W:0]   run_prio_q;
  logic [IW:0]       steps_q;
  walk_st_e          st_q;

  logic [ID_W-1:0]   top_link, cur_link, tgt_link;
  logic [PRIO_W:0]   pop_prio;

  function automatic logic [PRIO_W-1:0] prio_of(input logic [ID_W-1:0] id);
    logic [IW-1:0] ix;
    ix = id[IW-1:0];
    return prio_i[ix*PRIO_W +: PRIO_W];
  endfunction

  assign top_link = link_q[run_id_q[IW-1:0]];
  assign cur_link = link_q[cur_q[IW-1:0]];
  assign tgt_link = link_q[tgt_q[IW-1:0]];
  assign pop_prio = (top_link == NO_IRQ) ? IDLE_PRIO : {1'b0, prio_of(top_link)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_IRQ; i++) link_q[i] <= NO_IRQ;
      run_id_q   <= NO_IRQ;
      run_prio_q <= IDLE_PRIO;
      cur_q      <= NO_IRQ;
      tgt_q      <= NO_IRQ;
      steps_q    <= '0;
      st_q       <= WALK_IDLE;
    end else if (st_q == WALK_IDLE) begin
      if (ack_i) begin
        link_q[ack_id_i[IW-1:0]] <= run_id_q;
        run_id_q   <= ack_id_i;
        run_prio_q <= {1'b0, prio_of(ack_id_i)};
      end else if (eoi_i) begin
        if (eoi_id_i == run_id_q) begin
          run_id_q   <= top_link;
          run_prio_q <= pop_prio;
        end else begin
          cur_q   <= run_id_q;
          tgt_q   <= eoi_id_i;
          steps_q <= '0;
          st_q    <= WALK_RUN;
        end
      end
    end else begin
      // one link per cycle; step limit ends a corrupted chain
      if (cur_link == NO_IRQ || steps_q == (IW+1)'(N_IRQ - 1)) begin
        st_q <= WALK_IDLE;
      end else if (cur_link == tgt_q) begin
        link_q[cur_q[IW-1:0]] <= tgt_link;
        st_q <= WALK_IDLE;
      end else begin
        cur_q   <= cur_link;
        steps_q <= steps_q + 1'b1;
      end
    end
  end

  assign run_id_o   = run_id_q;
  assign run_prio_o = run_prio_q;
  assign busy_o     = (st_q == WALK_RUN);

  p_idle_prio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_id_q == NO_IRQ) == (run_prio_q == IDLE_PRIO));
  p_ack_raises_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> run_prio_q < $past(run_prio_q));
  p_walk_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(run_id_q));
endmodule

// File: rtl/cpuif_top.sv
module cpuif_top
  import cpuif_pkg::*;
#(
  parameter int N_IRQ = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dist_en_i,
  input  logic [N_IRQ-1:0]        irq_en_i,
  input  logic [N_IRQ-1:0]        irq_pend_i,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
  input  logic [N_IRQ-1:0]        irq_level_i,
  input  logic [N_IRQ-1:0]        irq_edge_i,
  input  logic [N_IRQ-1:0]        irq_bcast_i,
  input  logic [N_IRQ-1:0]        irq_tgt_i,
  input  logic                    reg_req_i,
  input  logic                    reg_wr_i,
  input  logic [4:0]              reg_addr_i,
  input  logic [31:0]             reg_wdata_i,
  output logic [31:0]             reg_rdata_o,
  output logic                    busy_o,
  output logic                    irq_o,
  output logic [N_IRQ-1:0]        pend_clr_o,
  output logic                    pend_clr_all_o,
  output logic [N_IRQ-1:0]        pend_set_o
);
  localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic              cpu_en_q, irq_q;
  logic [PRIO_W-1:0] mask_q;
  logic [ID_W-1:0]   hpp_q;

  logic              found;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;
  logic [ID_W-1:0]   run_id;
  logic [PRIO_W:0]   run_prio;
  logic              walk_busy;

  logic              acc, ack_ok, ack_fire, eoi_fire, repend;
  logic [IW-1:0]     hpp_ix, eoi_ix;
  logic [ID_W-1:0]   eoi_id;
  logic [PRIO_W-1:0] hpp_prio;

  cpuif_select #(.N_IRQ(N_IRQ)) u_select (
    .cand_i (irq_en_i & irq_pend_i),
    .prio_i (irq_prio_i),
    .found_o(found),
    .id_o   (best_id),
    .prio_o (best_prio)
  );

  assign acc      = reg_req_i && !walk_busy;
  assign hpp_ix   = hpp_q[IW-1:0];
  assign hpp_prio = irq_prio_i[hpp_ix*PRIO_W +: PRIO_W];
  assign ack_ok   = (hpp_q != NO_IRQ) && ({1'b0, hpp_prio} < run_prio);
  assign ack_fire = acc && !reg_wr_i && (reg_addr_i == OFF_ACK) && ack_ok;

  assign eoi_id   = reg_wdata_i[ID_W-1:0];
  assign eoi_ix   = eoi_id[IW-1:0];
  assign eoi_fire = acc && reg_wr_i && (reg_addr_i == OFF_EOI) &&
                    (run_id != NO_IRQ) && (eoi_id < ID_W'(N_IRQ));
  assign repend   = eoi_fire && !irq_edge_i[eoi_ix] && irq_en_i[eoi_ix] &&
                    irq_level_i[eoi_ix] && irq_tgt_i[eoi_ix];

  cpuif_chain #(.N_IRQ(N_IRQ)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prio_i    (irq_prio_i),
    .ack_i     (ack_fire),
    .ack_id_i  (hpp_q),
    .eoi_i     (eoi_fire),
    .eoi_id_i  (eoi_id),
    .run_id_o  (run_id),
    .run_prio_o(run_prio),
    .busy_o    (walk_busy)
  );

  assign pend_clr_o     = ack_fire ? (N_IRQ'(1) << hpp_ix) : '0;
  assign pend_clr_all_o = ack_fire && irq_bcast_i[hpp_ix];
  assign pend_set_o     = repend ? (N_IRQ'(1) << eoi_ix) : '0;

  always_comb begin
    case (reg_addr_i)
      OFF_CTRL: reg_rdata_o = 32'(cpu_en_q);
      OFF_MASK: reg_rdata_o = 32'(mask_q);
      OFF_ACK:  reg_rdata_o = ack_fire ? 32'(hpp_q) : 32'(NO_IRQ);
      OFF_RPRI: reg_rdata_o = 32'(run_prio);
      OFF_HPP:  reg_rdata_o = 32'(hpp_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_en_q <= 1'b0;
      mask_q   <= 8'hF0;
    end else if (acc && reg_wr_i) begin
      if (reg_addr_i == OFF_CTRL) cpu_en_q <= reg_wdata_i[0];
      if (reg_addr_i == OFF_MASK) mask_q   <= reg_wdata_i[PRIO_W-1:0];
    end
  end

  // held during a walk; a disable still forces the line low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hpp_q <= NO_IRQ;
      irq_q <= 1'b0;
    end else if (!dist_en_i || !cpu_en_q) begin
      hpp_q <= NO_IRQ;
      irq_q <= 1'b0;
    end else if (!walk_busy) begin
      if (found && best_prio <= mask_q) begin
        hpp_q <= best_id;
        irq_q <= {1'b0, best_prio} < run_prio;
      end else begin
        hpp_q <= NO_IRQ;
        irq_q <= 1'b0;
      end
    end
  end

  assign irq_o  = irq_q;
  assign busy_o = walk_busy;

  p_clr_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pend_clr_o));
  p_set_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pend_set_o));
  p_irq_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(dist_en_i && cpu_en_q));
  p_busy_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (pend_clr_o == '0 && pend_set_o == '0 && !pend_clr_all_o));
  p_hpp_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpp_q != NO_IRQ) |-> (hpp_q < ID_W'(N_IRQ)));
endmodule

// File: tb/test_cpuif_top.sv
`timescale 1ns/100ps
module test_cpuif_top;
  localparam int N = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dist_en;
  logic [N-1:0] en, pend, level, edge_s, bcast, tgt;
  logic [7:0] prio_b [N];
  logic [N*8-1:0] prio_flat;
  logic req, wr;
  logic [4:0] addr;
  logic [31:0] wdata, rdata;
  logic busy, irq;
  logic [N-1:0] clr, set_s;
  logic clr_all;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mask_b;
  logic [31:0] last_rd;
  logic [N-1:0] last_clr, last_set;
  logic last_all;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) prio_flat[i*8 +: 8] = prio_b[i];

  cpuif_top #(.N_IRQ(N)) i_cpuif_top (
    .clk_i(clk), .rst_ni(rst_n), .dist_en_i(dist_en),
    .irq_en_i(en), .irq_pend_i(pend), .irq_prio_i(prio_flat),
    .irq_level_i(level), .irq_edge_i(edge_s), .irq_bcast_i(bcast), .irq_tgt_i(tgt),
    .reg_req_i(req), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .busy_o(busy), .irq_o(irq),
    .pend_clr_o(clr), .pend_clr_all_o(clr_all), .pend_set_o(set_s)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    #1;
    last_rd = rdata; last_clr = clr; last_set = set_s; last_all = clr_all;
    @(negedge clk);
    req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a);
    access(1'b0, a, 32'h0);
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    access(1'b1, a, d);
    if (a == 5'h04 && !last_set[0] && 1'b1) mask_b = d[7:0];
  endtask

  function automatic int exp_hpp();
    int b = 1023;
    int bp = 256;
    for (int i = 0; i < N; i++)
      if (en[i] && pend[i] && int'(prio_b[i]) < bp) begin
        b = i; bp = int'(prio_b[i]);
      end
    if (b != 1023 && bp > int'(mask_b)) b = 1023;
    return b;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    dist_en = 1'b1; en = '0; pend = '0; level = '0; edge_s = '0; bcast = '0; tgt = '0;
    for (int i = 0; i < N; i++) prio_b[i] = 8'h00;
    req = 1'b0; wr = 1'b0; addr = '0; wdata = '0; mask_b = 8'hF0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    rd(5'h00); chk("R1 ctrl", int'(last_rd), 0);
    rd(5'h04); chk("R1 mask", int'(last_rd), 32'hF0);
    rd(5'h14); chk("R1 running prio", int'(last_rd), 32'h100);
    rd(5'h18); chk("R1 hpp", int'(last_rd), 1023);
    rd(5'h0C); chk("R6 ack idle", int'(last_rd), 1023);
    chk("R6 no clr when idle", int'(last_clr), 0);

    // R12 register readback
    wr_reg(5'h00, 32'h1);
    rd(5'h00); chk("R12 ctrl", int'(last_rd), 1);
    wr_reg(5'h04, 32'hFF);
    rd(5'h04); chk("R12 mask", int'(last_rd), 32'hFF);
    rd(5'h08); chk("R12 unmapped", int'(last_rd), 0);

    // R2 R3 R4 random patterns with many ties
    for (int it = 0; it < 60; it++) begin
      logic [7:0] m;
      m = (it % 4 == 0) ? 8'hFF : 8'($urandom_range(0, 255));
      wr_reg(5'h04, 32'(m));
      en = $urandom; pend = $urandom;
      for (int i = 0; i < N; i++) prio_b[i] = 8'($urandom_range(0, 3) << 6);
      @(negedge clk);
      chk("R4 irq random", int'(irq), int'(exp_hpp() != 1023));
      rd(5'h18); chk("R2 R3 hpp random", int'(last_rd), exp_hpp());
    end

    // R2 directed tie
    en = '1; pend = '0; wr_reg(5'h04, 32'hFF);
    for (int i = 0; i < N; i++) prio_b[i] = 8'h50;
    pend[9] = 1'b1; pend[5] = 1'b1;
    @(negedge clk);
    rd(5'h18); chk("R2 tie lowest id", int'(last_rd), 5);

    // R3 mask boundary
    pend = '0; pend[2] = 1'b1; prio_b[2] = 8'h80;
    wr_reg(5'h04, 32'h80); @(negedge clk);
    rd(5'h18); chk("R3 prio equal mask", int'(last_rd), 2);
    chk("R4 irq on equal mask", int'(irq), 1);
    wr_reg(5'h04, 32'h7F); @(negedge clk);
    rd(5'h18); chk("R3 prio above mask", int'(last_rd), 1023);
    chk("R3 irq masked", int'(irq), 0);

    // R5 disables
    wr_reg(5'h04, 32'hFF);
    wr_reg(5'h00, 32'h0); @(negedge clk);
    chk("R5 irq cpu off", int'(irq), 0);
    rd(5'h18); chk("R5 hpp cpu off", int'(last_rd), 1023);
    wr_reg(5'h00, 32'h1); dist_en = 1'b0; @(negedge clk); @(negedge clk);
    chk("R5 irq dist off", int'(irq), 0);
    rd(5'h18); chk("R5 hpp dist off", int'(last_rd), 1023);
    dist_en = 1'b1; pend = '0;

    // R6 R8 R9 nesting and out-of-order return
    prio_b[3] = 8'h80; prio_b[7] = 8'h40; prio_b[12] = 8'h20; prio_b[20] = 8'h20;
    pend[3] = 1'b1; @(negedge clk);
    chk("R4 irq first", int'(irq), 1);
    rd(5'h0C); chk("R6 ack 3", int'(last_rd), 3);
    chk("R6 clr 3", int'(last_clr), 32'h8);
    chk("R7 no bcast clr", int'(last_all), 0);
    pend[3] = 1'b0; pend[7] = 1'b1; @(negedge clk);
    rd(5'h14); chk("R6 running prio 3", int'(last_rd), 32'h80);
    chk("R4 preempt irq", int'(irq), 1);
    rd(5'h0C); chk("R6 ack 7", int'(last_rd), 7);
    pend[7] = 1'b0; pend[12] = 1'b1; @(negedge clk);
    rd(5'h0C); chk("R6 ack 12", int'(last_rd), 12);
    pend[12] = 1'b0; pend[20] = 1'b1; @(negedge clk); @(negedge clk);
    chk("R4 equal running no irq", int'(irq), 0);
    rd(5'h18); chk("R2 hpp 20", int'(last_rd), 20);
    rd(5'h0C); chk("R6 ack not below running", int'(last_rd), 1023);
    chk("R6 no clr refused", int'(last_clr), 0);
    pend[20] = 1'b0;

    wr_reg(5'h10, 32'd3);
    chk("R9 busy during walk", int'(busy), 1);
    wr_reg(5'h04, 32'h33);
    while (busy) @(negedge clk);
    rd(5'h04); chk("R9 access ignored when busy", int'(last_rd), 32'hFF);
    rd(5'h14); chk("R9 top unchanged", int'(last_rd), 32'h20);
    wr_reg(5'h10, 32'd12);
    rd(5'h14); chk("R8 pop to 7", int'(last_rd), 32'h40);
    wr_reg(5'h10, 32'd7);
    rd(5'h14); chk("R9 spliced entry skipped", int'(last_rd), 32'h100);

    // R11 level re-pend, edge no re-pend
    prio_b[4] = 8'h10; level[4] = 1'b1; tgt[4] = 1'b1; edge_s[4] = 1'b0;
    pend[4] = 1'b1; @(negedge clk);
    rd(5'h0C); chk("R6 ack 4", int'(last_rd), 4);
    pend[4] = 1'b0;
    wr_reg(5'h10, 32'd4); chk("R11 level repend", int'(last_set), 32'h10);
    edge_s[4] = 1'b1; pend[4] = 1'b1; @(negedge clk);
    rd(5'h0C); chk("R6 ack 4 edge", int'(last_rd), 4);
    pend[4] = 1'b0;
    wr_reg(5'h10, 32'd4); chk("R11 edge no repend", int'(last_set), 0);

    // R10 ignored returns
    edge_s[4] = 1'b0;
    wr_reg(5'h10, 32'd4); chk("R10 idle eoi no strobe", int'(last_set), 0);
    rd(5'h14); chk("R10 idle eoi prio", int'(last_rd), 32'h100);
    prio_b[6] = 8'h30; bcast[6] = 1'b1; pend[6] = 1'b1; @(negedge clk);
    rd(5'h0C); chk("R6 ack 6", int'(last_rd), 6);
    chk("R7 bcast clr", int'(last_all), 1);
    pend[6] = 1'b0;
    wr_reg(5'h10, 32'd40);
    rd(5'h14); chk("R10 out of range eoi", int'(last_rd), 32'h30);
    wr_reg(5'h10, 32'd6);
    rd(5'h14); chk("R8 pop to idle", int'(last_rd), 32'h100);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule